// File: doc/BRIEF.md
# Burst-Addressed SPI Configuration Target

This block is an SPI target that owns a small bank of byte-wide configuration registers for a clock-generation subsystem. A host selects the target with an active-low select, then shifts in a command byte that carries a 7-bit register address in its upper bits and a direction flag in its lowest bit. In a write, every following byte is stored at the next address in turn. In a read, the target shifts out the register at the named address, then the next one, and so on, for as long as select stays low.

The serial lines are oversampled by the system clock. SCLK, select and MOSI all pass through synchronizer stages, so the system clock must run several times faster than SCLK. The register bank sits at a parameterized base address. Addresses with no register behind it read as zero and drop writes. The whole bank is visible to the rest of the design as a flat bus. The low-power request bit, the two output-enable bits and the two 3-bit drive-strength fields are also brought out as registered decoded outputs.

Top module: `spi_cfg_target`

## Requirements
- R1: `spi_miso_oe` is low whenever `spi_cs_n` is high, and high while `spi_cs_n` is low.
- R2: The first byte after select falls is the command, sent most significant bit first. Bits 7..1 are the start address and bit 0 is the direction: 1 is a read and 0 is a write.
- R3: In a write, the byte after the command is stored at the start address and each later byte at the following address. Registers change only through such writes.
- R4: In a read, the byte after the command returns the register at the start address, each later byte returns the following address, and MOSI is ignored during those bytes.
- R5: MOSI is sampled on the rising SCLK edge. MISO changes only after a falling SCLK edge, so it is stable while SCLK is high.
- R6: Raising select in the middle of a byte discards the partial byte and resets the bit count. Bytes that were already complete keep their effect.
- R7: The address advances from 0x7F to 0x00 within a burst.
- R8: With the default base 0x10 and eight registers, mapped addresses are 0x10 to 0x17. A write to any other address is dropped, and a read from it returns 0x00.
- R9: After reset, register 0x11 holds 0xFF and every other register holds 0x00. `cfg_regs` carries register base+i in bits [8i+7:8i].
- R10: `hibernate` follows bit 5 of register 0x10. From register 0x11, `out1_en` follows bit 0, `out1_drive` bits 3..1, `out2_en` bit 4 and `out2_drive` bits 7..5. Each decoded output lags the register by one clock.
- R11: MISO is driven 0 for the whole command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock (idle low) |
| spi_cs_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Output enable for the MISO pad driver |
| cfg_regs | output | 64 | Flat view of all registers |
| hibernate | output | 1 | Low-power request |
| out1_en | output | 1 | Enable for clock output 1 |
| out1_drive | output | 3 | Drive strength for output 1 |
| out2_en | output | 1 | Enable for clock output 2 |
| out2_drive | output | 3 | Drive strength for output 2 |

## Verification
Some properties are checked by assertions on every cycle. MISO stays at zero through the command phase. MISO moves only after a detected falling edge or while deselected. Registers change only in the cycle after a write strobe. The address wraps from 0x7F to zero. Nothing is written while deselected. The decoded low-power output tracks its register bit.

Other behaviour only the bench scenarios can show. These include the mapping of burst data to addresses in both directions and the dropping of writes to unmapped addresses. They also include the zero returned by unmapped reads, the effect of a partial byte before an abort, and the reset contents. Random bursts around the mapped window, and bursts that cross the wrap point, are compared against a bench model of the register bank.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  typedef enum logic {
    PH_CMD  = 1'b0,
    PH_DATA = 1'b1
  } phase_t;

  localparam int HIB_BIT = 5;
  localparam int EN1_BIT = 0;
  localparam int EN2_BIT = 4;
  localparam int DRV1_LSB = 1;
  localparam int DRV2_LSB = 5;
  localparam int DRV_W = 3;
endpackage

// File: rtl/spi_cfg_sync.sv
module spi_cfg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_idle,
  output logic mosi_s
);
  logic [STAGES-1:0] sclk_p;
  logic [STAGES-1:0] cs_p;
  logic [STAGES-1:0] mosi_p;
  logic              sclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_p <= '0;
      cs_p   <= '1;
      mosi_p <= '0;
      sclk_d <= 1'b0;
    end else begin
      sclk_p <= {sclk_p[STAGES-2:0], sclk};
      cs_p   <= {cs_p[STAGES-2:0], cs_n};
      mosi_p <= {mosi_p[STAGES-2:0], mosi};
      sclk_d <= sclk_p[STAGES-1];
    end
  end

  assign sclk_rise = sclk_p[STAGES-1] & ~sclk_d;
  assign sclk_fall = ~sclk_p[STAGES-1] & sclk_d;
  assign cs_idle   = cs_p[STAGES-1];
  assign mosi_s    = mosi_p[STAGES-1];
endmodule

// File: rtl/spi_cfg_frame.sv
module spi_cfg_frame
  import spi_cfg_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              cs_idle,
  input  logic              mosi_s,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              byte_done,
  output logic              in_data,
  output logic              miso
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  phase_t            phase;
  logic              rnw;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] shin;
  logic [DATA_W-1:0] shin_nxt;
  logic [DATA_W-1:0] shout;
  logic              load_pend;

  assign shin_nxt = {shin[DATA_W-2:0], mosi_s};
  assign in_data  = (phase == PH_DATA);

  always_ff @(posedge clk) begin
    wr_en     <= 1'b0;
    byte_done <= 1'b0;
    if (rst) begin
      phase     <= PH_CMD;
      rnw       <= 1'b0;
      bit_cnt   <= '0;
      shin      <= '0;
      shout     <= '0;
      miso      <= 1'b0;
      load_pend <= 1'b0;
      cur_addr  <= '0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else if (cs_idle) begin
      phase     <= PH_CMD;
      bit_cnt   <= '0;
      shout     <= '0;
      miso      <= 1'b0;
      load_pend <= 1'b0;
    end else begin
      if (sclk_rise) begin
        shin <= shin_nxt;
        if (bit_cnt == LAST_BIT) begin
          bit_cnt   <= '0;
          byte_done <= 1'b1;
          load_pend <= 1'b1;
          if (phase == PH_CMD) begin
            cur_addr <= shin_nxt[DATA_W-1 -: ADDR_W];
            rnw      <= shin_nxt[0];
            phase    <= PH_DATA;
          end else begin
            if (!rnw) begin
              wr_en   <= 1'b1;
              wr_addr <= cur_addr;
              wr_data <= shin_nxt;
            end
            cur_addr <= cur_addr + 1'b1;
          end
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
      if (sclk_fall) begin
        if (load_pend) begin
          load_pend <= 1'b0;
          if (phase == PH_DATA && rnw) begin
            miso  <= rd_data[DATA_W-1];
            shout <= rd_data << 1;
          end else begin
            miso  <= 1'b0;
            shout <= '0;
          end
        end else begin
          miso  <= shout[DATA_W-1];
          shout <= shout << 1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_cfg_regfile.sv
module spi_cfg_regfile #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int BASE = 'h10,
  parameter int COUNT = 8,
  parameter logic [COUNT*DATA_W-1:0] RESET_VEC = '0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [DATA_W-1:0]       rd_data,
  output logic [COUNT*DATA_W-1:0] regs_flat
);
  logic [DATA_W-1:0] regs [COUNT];

  for (genvar i = 0; i < COUNT; i++) begin : g_reg
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(BASE + i);
    always_ff @(posedge clk) begin
      if (rst) begin
        regs[i] <= RESET_VEC[i*DATA_W +: DATA_W];
      end else if (wr_en && wr_addr == MY_ADDR) begin
        regs[i] <= wr_data;
      end
    end
    assign regs_flat[i*DATA_W +: DATA_W] = regs[i];
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < COUNT; i++) begin
      if (rd_addr == ADDR_W'(BASE + i)) rd_data = regs[i];
    end
  end
endmodule

// File: rtl/spi_cfg_target.sv
module spi_cfg_target
  import spi_cfg_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int REG_BASE = 'h10,
  parameter int REG_COUNT = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [REG_COUNT*DATA_W-1:0] RESET_VEC = 64'h0000_0000_0000_FF00
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        spi_sclk,
  input  logic                        spi_cs_n,
  input  logic                        spi_mosi,
  output logic                        spi_miso,
  output logic                        spi_miso_oe,
  output logic [REG_COUNT*DATA_W-1:0] cfg_regs,
  output logic                        hibernate,
  output logic                        out1_en,
  output logic [DRV_W-1:0]            out1_drive,
  output logic                        out2_en,
  output logic [DRV_W-1:0]            out2_drive
);
  localparam int PWR_IDX = 'h10 - REG_BASE;
  localparam int CTL_IDX = 'h11 - REG_BASE;
  localparam int PWR_LSB = PWR_IDX * DATA_W;
  localparam int CTL_LSB = CTL_IDX * DATA_W;

  logic              sclk_rise, sclk_fall, cs_idle, mosi_s;
  logic [ADDR_W-1:0] cur_addr, wr_addr;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic              wr_en, byte_done, in_data, miso_q;

  spi_cfg_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_idle(cs_idle), .mosi_s(mosi_s)
  );

  spi_cfg_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_frame (
    .clk(clk), .rst(rst), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_idle(cs_idle), .mosi_s(mosi_s), .rd_data(rd_data), .cur_addr(cur_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .byte_done(byte_done),
    .in_data(in_data), .miso(miso_q)
  );

  spi_cfg_regfile #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE(REG_BASE), .COUNT(REG_COUNT),
    .RESET_VEC(RESET_VEC)
  ) i_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(cur_addr), .rd_data(rd_data), .regs_flat(cfg_regs)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hibernate  <= 1'b0;
      out1_en    <= 1'b0;
      out1_drive <= '0;
      out2_en    <= 1'b0;
      out2_drive <= '0;
    end else begin
      hibernate  <= cfg_regs[PWR_LSB + HIB_BIT];
      out1_en    <= cfg_regs[CTL_LSB + EN1_BIT];
      out1_drive <= cfg_regs[CTL_LSB + DRV1_LSB +: DRV_W];
      out2_en    <= cfg_regs[CTL_LSB + EN2_BIT];
      out2_drive <= cfg_regs[CTL_LSB + DRV2_LSB +: DRV_W];
    end
  end

  assign spi_miso    = miso_q;
  assign spi_miso_oe = ~spi_cs_n;
endmodule

// File: rtl/spi_cfg_target_chk.sv
module spi_cfg_target_chk #(
  parameter int ADDR_W = 7,
  parameter int REGS_W = 64,
  parameter int HIB_POS = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              spi_miso,
  input logic              sclk_fall,
  input logic              cs_idle,
  input logic              in_data,
  input logic              byte_done,
  input logic              wr_en,
  input logic [ADDR_W-1:0] cur_addr,
  input logic [REGS_W-1:0] cfg_regs,
  input logic              hibernate
);
  AST_CMD_QUIET: assert property (@(posedge clk) disable iff (rst)
    !in_data |-> !spi_miso);  // R11

  AST_MISO_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(spi_miso) |-> ($past(sclk_fall) || $past(cs_idle)));  // R5

  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (byte_done && in_data && $past(in_data) && $past(cur_addr) == '1) |-> cur_addr == '0);  // R7

  AST_REG_WRITE_ONLY: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_regs) |-> $past(wr_en));  // R3

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    cs_idle |=> !wr_en);  // R6

  AST_HIB_TRACK: assert property (@(posedge clk) disable iff (rst)
    hibernate == $past(cfg_regs[HIB_POS]));  // R10
endmodule

bind spi_cfg_target spi_cfg_target_chk #(
  .ADDR_W(ADDR_W), .REGS_W(REG_COUNT*DATA_W), .HIB_POS(PWR_LSB + 5)
) i_chk (
  .clk(clk), .rst(rst), .spi_miso(spi_miso), .sclk_fall(sclk_fall),
  .cs_idle(cs_idle), .in_data(in_data), .byte_done(byte_done), .wr_en(wr_en),
  .cur_addr(cur_addr), .cfg_regs(cfg_regs), .hibernate(hibernate)
);

// File: tb/test_spi_cfg_target.sv
module test_spi_cfg_target;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic mosi = 1'b0;
  logic miso, miso_oe, hib, en1, en2;
  logic [2:0] drv1, drv2;
  logic [63:0] regs;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  logic [7:0] model [128];
  logic [7:0] wbuf [32];
  logic [7:0] rbuf [32];

  always #2 clk = ~clk;

  spi_cfg_target i_spi_cfg_target (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(miso_oe), .cfg_regs(regs), .hibernate(hib),
    .out1_en(en1), .out1_drive(drv1), .out2_en(en2), .out2_drive(drv2)
  );

  function automatic bit mapped(input logic [6:0] a);
    return a >= 7'h10 && a <= 7'h17;
  endfunction

  function automatic logic [63:0] model_flat();
    logic [63:0] f;
    for (int i = 0; i < 8; i++) f[i*8 +: 8] = model[16 + i];
    return f;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer_byte(input logic [7:0] tx, output logic [7:0] rx, inout bit edge_ok);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      if (miso !== rx[i]) edge_ok = 0;
      sclk = 1'b0;
    end
  endtask

  task automatic sel();
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic desel();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic burst(input logic [6:0] a, input logic rd, input int n);
    logic [7:0] rx;
    bit eok = 1;
    sel();
    chk("R1 oe while selected", miso_oe, 1'b1);
    xfer_byte({a, rd}, rx, eok);
    chk("R11 miso during command", rx, 8'h00);
    for (int k = 0; k < n; k++) begin
      xfer_byte(rd ? 8'($urandom) : wbuf[k], rbuf[k], eok);
    end
    desel();
    chk("R5 miso stable while sclk high", eok, 1'b1);
    for (int k = 0; k < n; k++) begin
      logic [6:0] ak = 7'(a + k);
      if (rd) chk(mapped(ak) ? "R4 read data" : "R8 unmapped read", rbuf[k], model[ak]);
      else if (mapped(ak)) model[ak] = wbuf[k];
    end
  endtask

  task automatic check_state();
    logic [7:0] c;
    c = model[7'h11];
    chk("R3 register bank", regs, model_flat());
    chk("R10 hibernate", hib, model[7'h10][5]);
    chk("R10 out1", {en1, drv1}, {c[0], c[3:1]});
    chk("R10 out2", {en2, drv2}, {c[4], c[7:5]});
    chk("R1 oe deselected", miso_oe, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] rx;
    bit eok;
    for (int i = 0; i < 128; i++) model[i] = 8'h00;
    model[7'h11] = 8'hFF;
    void'($urandom(32'h5EED_1234));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R9 reset contents and decoded outputs
    chk("R9 reset registers", regs, 64'h0000_0000_0000_FF00);
    chk("R9 reset decode", {hib, en1, drv1, en2, drv2}, {1'b0, 1'b1, 3'd7, 1'b1, 3'd7});
    chk("R1 oe after reset", miso_oe, 1'b0);

    // R2 R3 R10: directed write burst from 0x10
    wbuf[0] = 8'h20; wbuf[1] = 8'h5A; wbuf[2] = 8'hC3;
    burst(7'h10, 1'b0, 3);
    check_state();
    chk("R10 decode of 0x5A", {hib, en1, drv1, en2, drv2}, {1'b1, 1'b0, 3'd5, 1'b1, 3'd2});

    // R4 directed read across whole bank and past it
    burst(7'h10, 1'b1, 10);

    // R7 R8 wrap with write that reaches mapped space
    for (int k = 0; k < 20; k++) wbuf[k] = 8'(8'h80 + k);
    burst(7'h7F, 1'b0, 20);
    check_state();
    chk("R7 wrapped write landed", model[7'h10], 8'h91);
    burst(7'h7E, 1'b1, 20);

    // R6 abort mid-byte: full byte kept, partial byte dropped
    sel();
    eok = 1;
    xfer_byte({7'h14, 1'b0}, rx, eok);
    xfer_byte(8'hA5, rx, eok);
    for (int i = 7; i >= 5; i--) begin
      mosi = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    desel();
    model[7'h14] = 8'hA5;
    burst(7'h14, 1'b1, 2);
    chk("R6 partial byte dropped", rbuf[1], model[7'h15]);
    chk("R6 full byte kept", rbuf[0], 8'hA5);

    // R6 abort during command, then a normal transfer must still frame correctly
    sel();
    for (int i = 0; i < 5; i++) begin
      mosi = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    desel();
    wbuf[0] = 8'h3C;
    burst(7'h16, 1'b0, 1);
    burst(7'h16, 1'b1, 1);
    chk("R6 framing after aborted command", rbuf[0], 8'h3C);
    check_state();

    // random bursts around the mapped window, checked against the model
    for (int t = 0; t < 40; t++) begin
      logic [6:0] a;
      logic rd;
      int n;
      a = ($urandom % 4 == 0) ? 7'($urandom) : 7'(12 + $urandom % 16);
      rd = 1'($urandom);
      n = 1 + int'($urandom % 10);
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      burst(a, rd, n);
      check_state();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule